// File: doc/BRIEF.md
# Strobe-Multiplexed Mode Input Decoder

This block recovers the operating configuration of a multi-function counter/timer from four single-wire sense inputs. Each sense wire is strapped externally to one or more digit strobe lines of the display scanner. A wire that reads high during the slot of a given digit selects the setting tied to that digit. The four wires select the measurement function, the gate range, a set of control flags, and the digits that carry an external decimal point. The scanner visits the digits from the most significant (index NDIG-1) down to the least significant (index 0). It provides the digit index, a strobe that is high while a digit slot is active, and a phase signal that is high in the second half of each slot, when the sense wires are stable.

The decoder gathers the samples of one complete scan. It commits them together when the least significant slot ends, so the outputs never show a mix of two scans. Whenever the committed function or range changes, it raises a one-clock change pulse for the measurement sequencer. A display-off request freezes the decoder until the hold input is released.

Top module: `strobe_mode_decoder`

## Requirements
- R1: After a synchronous reset, the function code is 0 (frequency), the range code is 0, every control flag is 0, the decimal point mask is 0 and the change pulse is low.
- R2: The function code follows the digit that sees the function wire high: D1 gives 0 (frequency), D2 gives 1 (ratio), D3 gives 2 (oscillator self test), D4 gives 3 (unit count), D5 gives 4 (time interval) and D8 gives 5 (period). D6 and D7 select nothing. Digit Dn is index n-1.
- R3: The range code follows the digit that sees the range wire high: D1 gives 0, D2 gives 1, D3 gives 2, D4 gives 3 and D5 gives 4 (external gate). D6 to D8 select nothing.
- R4: The control flags follow the digits that see the control wire high, and any combination may be active at once: D1 sets external timebase, D2 sets 1 MHz timebase, D3 sets external decimal point enable and D8 sets display test. The flags are replaced by each committed scan.
- R5: A sense level seen only in the first half of a slot (phase low) has no effect.
- R6: Settings are committed only at the end of the D1 slot of a scan in which all NDIG slots were sampled. A scan that began part way through is discarded.
- R7: The change pulse is high for exactly one clock, in the cycle the new values appear, and only when the committed function or range differs from its previous value. A scan that changes only flags or repeats the same settings gives no pulse.
- R8: If no valid digit matches the function wire or the range wire during a full scan, that setting keeps its previous value.
- R9: The decimal point mask has a 1 at each digit index whose slot saw the decimal point wire high, provided the same scan enabled the external decimal point. Otherwise the mask is 0.
- R10: Display off becomes active when a committed scan saw the control wire high at D4 while hold is high. While it is active, scans change no output. It clears one clock after hold goes low.
- R11: When several valid digits match the function or range wire in one scan, the lowest-numbered digit wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_idx | input | 3 | Index of the digit slot in progress, 0 = D1 |
| scan_strobe | input | 1 | High while a digit slot is active |
| scan_late | input | 1 | High during the second half of the slot |
| hold_in | input | 1 | Hold level, needed for display off and releasing it |
| sns_fn | input | 1 | Function sense wire |
| sns_rng | input | 1 | Range sense wire |
| sns_ctl | input | 1 | Control sense wire |
| sns_dp | input | 1 | Decimal point sense wire |
| fn_sel | output | 3 | Committed function code |
| rng_sel | output | 3 | Committed range code |
| ext_osc_en | output | 1 | External timebase flag |
| mhz1_sel | output | 1 | 1 MHz timebase flag |
| ext_dp_en | output | 1 | External decimal point enable flag |
| disp_test | output | 1 | Display test flag |
| disp_off | output | 1 | Display off active |
| dp_mask | output | 8 | Digits carrying an external decimal point |
| cfg_change | output | 1 | One-clock pulse on function or range change |

## Verification
Two events can fall on the same clock edge: the commit that carries a new function, which raises the change pulse, and the entry into display off, which then freezes every later scan. The bench provokes this with one scan that both moves the function to unit count and asserts the control wire at D4 with hold high. It then checks that the new function, one change pulse and display off all appear together. It also checks that the next scan, which requests a different function while display off is active, changes nothing, and that the decoder resumes after hold is released.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

  localparam int NCH    = 4;
  localparam int CH_FN  = 0;
  localparam int CH_RNG = 1;
  localparam int CH_CTL = 2;
  localparam int CH_DP  = 3;

  localparam logic [2:0] FN_FREQ   = 3'd0;
  localparam logic [2:0] FN_RATIO  = 3'd1;
  localparam logic [2:0] FN_OSC    = 3'd2;
  localparam logic [2:0] FN_UNIT   = 3'd3;
  localparam logic [2:0] FN_TINT   = 3'd4;
  localparam logic [2:0] FN_PERIOD = 3'd5;

  localparam logic [2:0] RG_EXT = 3'd4;

  typedef struct packed {
    logic ext_osc;
    logic mhz1;
    logic ext_dp;
    logic off_req;
    logic test;
  } ctl_t;

  // {valid, code} for the function tied to digit index d
  function automatic logic [3:0] fn_lookup(input int unsigned d, input int unsigned ndig);
    logic [3:0] r;
    r = 4'b0;
    if (d == ndig - 1) r = {1'b1, FN_PERIOD};
    else begin
      case (d)
        0: r = {1'b1, FN_FREQ};
        1: r = {1'b1, FN_RATIO};
        2: r = {1'b1, FN_OSC};
        3: r = {1'b1, FN_UNIT};
        4: r = {1'b1, FN_TINT};
        default: r = 4'b0;
      endcase
    end
    return r;
  endfunction

  // {valid, code} for the range tied to digit index d
  function automatic logic [3:0] rng_lookup(input int unsigned d);
    logic [3:0] r;
    if (d <= 4) r = {1'b1, 3'(d)};
    else        r = 4'b0;
    return r;
  endfunction

endpackage

// File: rtl/mdec_sampler.sv
module mdec_sampler
  import mdec_pkg::*;
#(
  parameter int NDIG = 8,
  localparam int IDXW = $clog2(NDIG)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  input  logic                       strobe,
  input  logic                       late,
  input  logic [IDXW-1:0]            idx,
  input  logic [NCH-1:0]             sense,
  output logic [NCH-1:0][NDIG-1:0]   acc,
  output logic                       full,
  output logic                       scan_end
);

  logic                 take;
  logic                 in_last;
  logic                 last_q;
  logic [NDIG-1:0]      seen_q;
  logic [NDIG-1:0]      hit;
  logic [NCH-1:0][NDIG-1:0] acc_q;

  assign take    = en & strobe & late;
  assign in_last = strobe & late & (idx == '0);
  assign scan_end = last_q & ~in_last;
  assign full    = &seen_q;
  assign acc     = acc_q;

  always_comb begin
    hit = '0;
    if (take) hit[idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= 1'b0;
      seen_q <= '0;
    end else begin
      last_q <= in_last;
      seen_q <= (scan_end ? '0 : seen_q) | hit;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) acc_q[c] <= '0;
      else     acc_q[c] <= (scan_end ? '0 : acc_q[c]) | (sense[c] ? hit : '0);
    end
  end

  // R6: a scan boundary with no new sample leaves nothing gathered
  p_seen_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (scan_end && !take) |=> (seen_q == '0));

endmodule

// File: rtl/mdec_decode.sv
module mdec_decode
  import mdec_pkg::*;
#(
  parameter int NDIG = 8
) (
  input  logic [NCH-1:0][NDIG-1:0] acc,
  output logic                     fn_hit,
  output logic [2:0]               fn_val,
  output logic                     rng_hit,
  output logic [2:0]               rng_val,
  output ctl_t                     ctl,
  output logic [NDIG-1:0]          dp
);

  logic [3:0] fl;
  logic [3:0] rl;

  // scan from the top down so the lowest matching digit wins (R11)
  always_comb begin
    fn_hit  = 1'b0;
    fn_val  = FN_FREQ;
    rng_hit = 1'b0;
    rng_val = 3'd0;
    fl = 4'b0;
    rl = 4'b0;
    for (int d = NDIG - 1; d >= 0; d--) begin
      fl = fn_lookup(d, NDIG);
      rl = rng_lookup(d);
      if (acc[CH_FN][d] && fl[3]) begin
        fn_hit = 1'b1;
        fn_val = fl[2:0];
      end
      if (acc[CH_RNG][d] && rl[3]) begin
        rng_hit = 1'b1;
        rng_val = rl[2:0];
      end
    end
  end

  always_comb begin
    ctl.ext_osc = acc[CH_CTL][0];
    ctl.mhz1    = acc[CH_CTL][1];
    ctl.ext_dp  = acc[CH_CTL][2];
    ctl.off_req = acc[CH_CTL][3];
    ctl.test    = acc[CH_CTL][NDIG-1];
    dp          = acc[CH_CTL][2] ? acc[CH_DP] : '0;
  end

endmodule

// File: rtl/mdec_commit.sv
module mdec_commit
  import mdec_pkg::*;
#(
  parameter int NDIG = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scan_end,
  input  logic            full,
  input  logic            hold,
  input  logic            fn_hit,
  input  logic [2:0]      fn_val,
  input  logic            rng_hit,
  input  logic [2:0]      rng_val,
  input  ctl_t            ctl,
  input  logic [NDIG-1:0] dp,
  output logic            sample_en,
  output logic [2:0]      fn_q,
  output logic [2:0]      rng_q,
  output ctl_t            ctl_q,
  output logic [NDIG-1:0] dp_q,
  output logic            off_q,
  output logic            chg_q
);

  logic       commit;
  logic [2:0] fn_nx;
  logic [2:0] rng_nx;

  assign commit    = scan_end & full & ~off_q;
  assign fn_nx     = (commit & fn_hit)  ? fn_val  : fn_q;
  assign rng_nx    = (commit & rng_hit) ? rng_val : rng_q;
  assign sample_en = ~off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fn_q  <= FN_FREQ;
      rng_q <= 3'd0;
      ctl_q <= '0;
      dp_q  <= '0;
      off_q <= 1'b0;
      chg_q <= 1'b0;
    end else begin
      fn_q  <= fn_nx;
      rng_q <= rng_nx;
      if (commit) begin
        ctl_q <= ctl;
        dp_q  <= dp;
      end
      off_q <= hold & (off_q | (commit & ctl.off_req));
      chg_q <= commit & ((fn_nx != fn_q) | (rng_nx != rng_q));
    end
  end

  // R7: the change pulse never lasts two clocks
  p_chg_single_r7: assert property (@(posedge clk) disable iff (rst)
    chg_q |=> !chg_q);

endmodule

// File: rtl/strobe_mode_decoder.sv
module strobe_mode_decoder
  import mdec_pkg::*;
#(
  parameter int NDIG = 8,
  localparam int IDXW = $clog2(NDIG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IDXW-1:0] scan_idx,
  input  logic            scan_strobe,
  input  logic            scan_late,
  input  logic            hold_in,
  input  logic            sns_fn,
  input  logic            sns_rng,
  input  logic            sns_ctl,
  input  logic            sns_dp,
  output logic [2:0]      fn_sel,
  output logic [2:0]      rng_sel,
  output logic            ext_osc_en,
  output logic            mhz1_sel,
  output logic            ext_dp_en,
  output logic            disp_test,
  output logic            disp_off,
  output logic [NDIG-1:0] dp_mask,
  output logic            cfg_change
);

  logic [NCH-1:0]           sense;
  logic [NCH-1:0][NDIG-1:0] acc;
  logic                     full;
  logic                     scan_end;
  logic                     sample_en;
  logic                     fn_hit;
  logic [2:0]               fn_val;
  logic                     rng_hit;
  logic [2:0]               rng_val;
  ctl_t                     ctl_d;
  ctl_t                     ctl_q;
  logic [NDIG-1:0]          dp_d;

  always_comb begin
    sense         = '0;
    sense[CH_FN]  = sns_fn;
    sense[CH_RNG] = sns_rng;
    sense[CH_CTL] = sns_ctl;
    sense[CH_DP]  = sns_dp;
  end

  mdec_sampler #(.NDIG(NDIG)) u_smp (
    .clk(clk), .rst(rst), .en(sample_en),
    .strobe(scan_strobe), .late(scan_late), .idx(scan_idx),
    .sense(sense), .acc(acc), .full(full), .scan_end(scan_end)
  );

  mdec_decode #(.NDIG(NDIG)) u_dec (
    .acc(acc), .fn_hit(fn_hit), .fn_val(fn_val),
    .rng_hit(rng_hit), .rng_val(rng_val), .ctl(ctl_d), .dp(dp_d)
  );

  mdec_commit #(.NDIG(NDIG)) u_cmt (
    .clk(clk), .rst(rst), .scan_end(scan_end), .full(full), .hold(hold_in),
    .fn_hit(fn_hit), .fn_val(fn_val), .rng_hit(rng_hit), .rng_val(rng_val),
    .ctl(ctl_d), .dp(dp_d), .sample_en(sample_en),
    .fn_q(fn_sel), .rng_q(rng_sel), .ctl_q(ctl_q), .dp_q(dp_mask),
    .off_q(disp_off), .chg_q(cfg_change)
  );

  assign ext_osc_en = ctl_q.ext_osc;
  assign mhz1_sel   = ctl_q.mhz1;
  assign ext_dp_en  = ctl_q.ext_dp;
  assign disp_test  = ctl_q.test;

  // R10: while display off is active the settings stay frozen
  p_freeze_off_r10: assert property (@(posedge clk) disable iff (rst)
    disp_off |=> ($stable(fn_sel) && $stable(rng_sel) && $stable(dp_mask)));

  // R10: releasing hold clears display off on the next clock
  p_hold_release_r10: assert property (@(posedge clk) disable iff (rst)
    !hold_in |=> !disp_off);

  // R9: a decimal point is only shown with the enable flag
  p_dp_gate_r9: assert property (@(posedge clk) disable iff (rst)
    (dp_mask != '0) |-> ext_dp_en);

  // R7: a pulse always goes with a changed function or range
  p_chg_diff_r7: assert property (@(posedge clk) disable iff (rst)
    cfg_change |-> ((fn_sel != $past(fn_sel)) || (rng_sel != $past(rng_sel))));

  // R2: only defined function codes appear
  p_fn_legal_r2: assert property (@(posedge clk) disable iff (rst)
    fn_sel <= FN_PERIOD);

endmodule

// File: tb/strobe_mode_decoder_tb.sv
module strobe_mode_decoder_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] scan_idx = '0;
  logic       scan_strobe = 1'b0;
  logic       scan_late = 1'b0;
  logic       hold_in = 1'b0;
  logic       sns_fn = 1'b0, sns_rng = 1'b0, sns_ctl = 1'b0, sns_dp = 1'b0;
  logic [2:0] fn_sel, rng_sel;
  logic       ext_osc_en, mhz1_sel, ext_dp_en, disp_test, disp_off, cfg_change;
  logic [7:0] dp_mask;

  int checks = 0;
  int fails  = 0;
  int chg_cnt = 0;
  bit done = 1'b0;
  logic [2:0] e_fn = 3'd0, e_rng = 3'd0;

  always #2.5 clk = ~clk;

  strobe_mode_decoder dut_i (
    .clk(clk), .rst(rst), .scan_idx(scan_idx), .scan_strobe(scan_strobe),
    .scan_late(scan_late), .hold_in(hold_in), .sns_fn(sns_fn), .sns_rng(sns_rng),
    .sns_ctl(sns_ctl), .sns_dp(sns_dp), .fn_sel(fn_sel), .rng_sel(rng_sel),
    .ext_osc_en(ext_osc_en), .mhz1_sel(mhz1_sel), .ext_dp_en(ext_dp_en),
    .disp_test(disp_test), .disp_off(disp_off), .dp_mask(dp_mask),
    .cfg_change(cfg_change)
  );

  always @(negedge clk) if (!rst && cfg_change) chg_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one scan from digit 'first' down to D1; noisy = all wires high in early halves
  task automatic scan(input logic [7:0] fm, input logic [7:0] rm, input logic [7:0] cm,
                      input logic [7:0] dm, input int first, input bit noisy);
    for (int d = first; d >= 0; d--) begin
      @(negedge clk);
      scan_idx = 3'(d); scan_strobe = 1'b1; scan_late = 1'b0;
      {sns_fn, sns_rng, sns_ctl, sns_dp} = noisy ? 4'hF : 4'h0;
      @(negedge clk);
      @(negedge clk);
      scan_late = 1'b1;
      sns_fn = fm[d]; sns_rng = rm[d]; sns_ctl = cm[d]; sns_dp = dm[d];
      @(negedge clk);
      @(negedge clk);
      scan_strobe = 1'b0; scan_late = 1'b0;
      {sns_fn, sns_rng, sns_ctl, sns_dp} = 4'h0;
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 fn", fn_sel, 0);
    chk("R1 rng", rng_sel, 0);
    chk("R1 flags", {ext_osc_en, mhz1_sel, ext_dp_en, disp_test, disp_off}, 0);
    chk("R1 dp", dp_mask, 0);
    chk("R1 chg", cfg_change, 0);
  endtask

  task automatic t_functions();
    int c0;
    int dig[6] = '{0, 1, 2, 3, 4, 7};
    int code[6] = '{0, 1, 2, 3, 4, 5};
    for (int k = 0; k < 6; k++) begin
      c0 = chg_cnt;
      scan(8'(1 << dig[k]), 8'h01, 8'h00, 8'h00, 7, 1'b0);
      chk("R2 function code", fn_sel, code[k]);
      chk("R7 pulse count", chg_cnt - c0, (k == 0) ? 0 : 1);
    end
    e_fn = 3'd5;
  endtask

  task automatic t_ranges();
    for (int k = 0; k < 5; k++) begin
      scan(8'h80, 8'(1 << k), 8'h00, 8'h00, 7, 1'b0);
      chk("R3 range code", rng_sel, k);
    end
    e_rng = 3'd4;
  endtask

  task automatic t_flags();
    int c0 = chg_cnt;
    scan(8'h80, 8'h10, 8'h8F, 8'h00, 7, 1'b0);
    chk("R4 flags ext/1M/dp/test", {ext_osc_en, mhz1_sel, ext_dp_en, disp_test}, 4'hF);
    chk("R10 no off without hold", disp_off, 0);
    chk("R7 flags only no pulse", chg_cnt - c0, 0);
    scan(8'h80, 8'h10, 8'h02, 8'h00, 7, 1'b0);
    chk("R4 flags replaced", {ext_osc_en, mhz1_sel, ext_dp_en, disp_test}, 4'b0100);
  endtask

  task automatic t_dp();
    scan(8'h80, 8'h10, 8'h04, 8'h24, 7, 1'b0);
    chk("R9 dp mask", dp_mask, 8'h24);
    scan(8'h80, 8'h10, 8'h00, 8'h24, 7, 1'b0);
    chk("R9 dp disabled", dp_mask, 0);
  endtask

  task automatic t_early();
    scan(8'h02, 8'h10, 8'h00, 8'h00, 7, 1'b1);
    chk("R5 early half ignored fn", fn_sel, 1);
    chk("R5 early half ignored flags", {ext_osc_en, mhz1_sel, ext_dp_en, disp_test}, 0);
    e_fn = 3'd1;
  endtask

  task automatic t_partial();
    int c0 = chg_cnt;
    scan(8'h01, 8'h01, 8'h00, 8'h00, 3, 1'b0);
    chk("R6 partial scan fn", fn_sel, e_fn);
    chk("R6 partial scan rng", rng_sel, e_rng);
    chk("R6 partial no pulse", chg_cnt - c0, 0);
  endtask

  task automatic t_nomatch();
    scan(8'h60, 8'hE0, 8'h00, 8'h00, 7, 1'b0);
    chk("R8 fn kept", fn_sel, e_fn);
    chk("R8 rng kept", rng_sel, e_rng);
  endtask

  task automatic t_priority();
    scan(8'h12, 8'h0C, 8'h00, 8'h00, 7, 1'b0);
    chk("R11 fn lowest digit", fn_sel, 1);
    chk("R11 rng lowest digit", rng_sel, 2);
    e_rng = 3'd2;
  endtask

  task automatic t_display_off();
    int c0;
    hold_in = 1'b1;
    c0 = chg_cnt;
    scan(8'h08, 8'h04, 8'h08, 8'h00, 7, 1'b0);
    chk("R10 off entered", disp_off, 1);
    chk("R2 unit count with off", fn_sel, 3);
    chk("R7 pulse with off entry", chg_cnt - c0, 1);
    c0 = chg_cnt;
    scan(8'h80, 8'h01, 8'h84, 8'h01, 7, 1'b0);
    chk("R10 frozen fn", fn_sel, 3);
    chk("R10 frozen rng", rng_sel, 2);
    chk("R10 frozen flags", {ext_dp_en, disp_test}, 0);
    chk("R10 frozen no pulse", chg_cnt - c0, 0);
    @(negedge clk); hold_in = 1'b0;
    @(negedge clk);
    chk("R10 released", disp_off, 0);
    c0 = chg_cnt;
    scan(8'h80, 8'h04, 8'h00, 8'h00, 7, 1'b0);
    chk("R10 resumed fn", fn_sel, 5);
    chk("R7 pulse after resume", chg_cnt - c0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_functions();
    t_ranges();
    t_flags();
    t_dp();
    t_early();
    t_partial();
    t_nomatch();
    t_priority();
    t_display_off();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule